// File: doc/BRIEF.md
# Duty-Limited Forward-Converter Gate Pulse Generator

This block produces the single gate-drive pulse per switching period for a one-switch forward converter. A phase counter runs freely over a fixed number of clock cycles. In each period the gate rises on the first phase and stays high while three conditions all hold. The duty command must still lie above a rising ramp. The phase must lie below a hard ceiling of three quarters of the period. A volt-second integrator must not have passed its threshold.

The duty command is the lower of a soft-start level and a feedback level. As soft-start ramps up, the soft-start level steers the pulse width. Once it climbs past the feedback level, the feedback level takes over. The ramp top can be either a fixed parameter or a scaled copy of the line-voltage word, which gives input-voltage feedforward.

While the gate is high, the integrator adds the line-voltage word on every clock. While the gate is low, it is held at zero. A volt-second cut is not a fault: it only shortens the current pulse. A fault-kill input removes the pulse at once.

All inputs are level controls, sampled on every clock edge. They carry no stream of data, so the block has no valid/ready handshake and exerts no back-pressure.

Top module: `fwd_gate_pwm`

## Requirements
- R1: The gate is never high for more than MAXON = PERIOD*3/4 consecutive clock cycles, which is 12 with the default PERIOD of 16.
- R2: With inputs held steady, the gate is high exactly during phases 0..n-1 of each period. Here n = min(n_cmd, MAXON, n_vs), and n_cmd is the count of phases q with cmd*MAXON > q*top.
- R3: The duty command cmd is the smaller of ss_lvl and fb_lvl, so either input alone can narrow the pulse.
- R4: The volt-second sum starts each pulse at zero and adds line_word on every high cycle. The pulse ends after the cycle in which the sum exceeds vs_lim, so n_vs = floor(vs_lim/line_word)+1. A line_word of 0 never ends a pulse.
- R5: A volt-second cut is not latched. The next period produces a pulse of the same computed length.
- R6: The ramp top is the parameter RAMP_TOP (default 200) when ff_en=0. It is (line_word*169)>>8, roughly 66 % of the line word, when ff_en=1.
- R7: When kill is high at a clock edge, the gate is low after that edge. The gate stays low for the rest of that period even if kill drops, and pulses resume at the next period start.
- R8: The gate rises only at phase 0, so at most one pulse occurs per period. A command of 0 gives no pulse.
- R9: The gate is low during reset and on each edge where en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the gate off and rewinds the phase |
| kill | input | 1 | Fault kill; forces the gate off |
| ss_lvl | input | DUTY_W | Soft-start duty level |
| fb_lvl | input | DUTY_W | Feedback duty level |
| ff_en | input | 1 | Selects the line-scaled ramp top |
| line_word | input | LINE_W | Sampled input-voltage word |
| vs_lim | input | VS_W | Volt-second threshold |
| gate | output | 1 | Gate-drive pulse |

## Verification
The three pulse terminators can reach the same phase: the duty compare, the 75 % ceiling and the volt-second cut. The bench provokes this with directed cases where two limits give an equal length, such as a command that reaches exactly the ceiling and a volt-second count that equals the duty count. It also sweeps random commands, line words and thresholds so that the winning limit changes from case to case. Each case is judged by the count of high cycles over one full period and the number of rising edges, both compared against the minimum of the three terms that a bench function computes.

// File: rtl/fwd_pwm_pkg.sv
package fwd_pwm_pkg;
  // feedforward ramp scale: top = (line * FF_NUM) >> FF_SH  (~0.66)
  localparam int unsigned FF_NUM = 169;
  localparam int unsigned FF_SH  = 8;

  function automatic int unsigned max_on_cycles(input int unsigned period);
    return (period * 3) / 4;
  endfunction
endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
  parameter int unsigned PERIOD = 16,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] phase_q,
  output logic [CW-1:0] phase_nx,
  output logic          start_nx
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  // held at LAST while disabled so the first enabled edge opens a period
  always_comb begin
    if (!en)                 phase_nx = LAST;
    else if (phase_q == LAST) phase_nx = '0;
    else                     phase_nx = phase_q + 1'b1;
  end

  assign start_nx = en && (phase_nx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= LAST;
    else        phase_q <= phase_nx;
  end

  p_phase_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && phase_q == LAST) |=> (phase_q == '0));
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
  import fwd_pwm_pkg::*;
#(
  parameter int unsigned PERIOD   = 16,
  parameter int unsigned DUTY_W   = 8,
  parameter int unsigned LINE_W   = 8,
  parameter int unsigned RAMP_TOP = 200,
  parameter int unsigned CW       = $clog2(PERIOD)
) (
  input  logic [DUTY_W-1:0] ss_lvl,
  input  logic [DUTY_W-1:0] fb_lvl,
  input  logic              ff_en,
  input  logic [LINE_W-1:0] line_word,
  input  logic [CW-1:0]     phase_nx,
  output logic              in_window
);
  localparam int unsigned   MAXON   = max_on_cycles(PERIOD);
  localparam int unsigned   PW      = DUTY_W + LINE_W + CW + 1;
  localparam logic [CW-1:0] MAXON_C = CW'(MAXON);

  logic [DUTY_W-1:0] cmd;
  logic [PW-1:0]     top, scaled, lhs, rhs;

  always_comb begin
    cmd    = (ss_lvl < fb_lvl) ? ss_lvl : fb_lvl;
    scaled = (PW'(line_word) * PW'(FF_NUM)) >> FF_SH;
    top    = ff_en ? scaled : PW'(RAMP_TOP);
    lhs    = PW'(cmd) * PW'(MAXON);
    rhs    = PW'(phase_nx) * top;
    in_window = (phase_nx < MAXON_C) && (lhs > rhs);
  end
endmodule

// File: rtl/vs_integ.sv
module vs_integ #(
  parameter int unsigned LINE_W = 8,
  parameter int unsigned AW     = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_q,
  input  logic [LINE_W-1:0] line_word,
  input  logic [AW-1:0]     vs_lim,
  output logic              trip
);
  logic [AW-1:0] acc, acc_sum;

  assign acc_sum = acc + AW'(line_word);
  assign trip    = acc_sum > vs_lim;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (gate_q) acc <= acc_sum;
    else             acc <= '0;
  end

  // a pulse still running under steady inputs has never passed the limit
  p_acc_within_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && $past(gate_q) && $stable(vs_lim) && $stable(line_word))
      |-> (acc <= vs_lim));
endmodule

// File: rtl/fwd_gate_pwm.sv
module fwd_gate_pwm
  import fwd_pwm_pkg::*;
#(
  parameter  int unsigned PERIOD   = 16,
  parameter  int unsigned DUTY_W   = 8,
  parameter  int unsigned LINE_W   = 8,
  parameter  int unsigned RAMP_TOP = 200,
  localparam int unsigned CW       = $clog2(PERIOD),
  localparam int unsigned VS_W     = LINE_W + CW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              kill,
  input  logic [DUTY_W-1:0] ss_lvl,
  input  logic [DUTY_W-1:0] fb_lvl,
  input  logic              ff_en,
  input  logic [LINE_W-1:0] line_word,
  input  logic [VS_W-1:0]   vs_lim,
  output logic              gate
);
  localparam int unsigned MAXON = max_on_cycles(PERIOD);

  logic [CW-1:0] phase_q, phase_nx;
  logic          start_nx, in_window, trip, gate_q, gate_nx;
  logic [CW:0]   on_run;

  pwm_phase_ctr #(.PERIOD(PERIOD), .CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(en),
    .phase_q(phase_q), .phase_nx(phase_nx), .start_nx(start_nx));

  pwm_duty_cmp #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .LINE_W(LINE_W),
                 .RAMP_TOP(RAMP_TOP), .CW(CW)) u_cmp (
    .ss_lvl(ss_lvl), .fb_lvl(fb_lvl), .ff_en(ff_en), .line_word(line_word),
    .phase_nx(phase_nx), .in_window(in_window));

  vs_integ #(.LINE_W(LINE_W), .AW(VS_W)) u_vs (
    .clk(clk), .rst_n(rst_n), .gate_q(gate_q), .line_word(line_word),
    .vs_lim(vs_lim), .trip(trip));

  // rise only at period start; once low, stay low until the next start
  always_comb begin
    if (!en || kill)   gate_nx = 1'b0;
    else if (start_nx) gate_nx = in_window;
    else               gate_nx = gate_q && in_window && !trip;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_nx;
  end

  assign gate = gate_q;

  // run length of the current high stretch, for the ceiling check
  always_ff @(posedge clk) begin
    if (!rst_n)      on_run <= '0;
    else if (gate_q) on_run <= on_run + 1'b1;
    else             on_run <= '0;
  end

  p_max_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (on_run < (CW+1)'(MAXON)));

  p_kill_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !gate_q);

  p_rise_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> (phase_q == '0));

  p_en_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate_q);
endmodule

// File: tb/tb_fwd_gate_pwm.sv
`timescale 1ns/1ps
module tb_fwd_gate_pwm;
  localparam int PERIOD = 16;
  localparam int MAXON  = 12;
  localparam int TOPFIX = 200;
  localparam int VS_W   = 13;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, kill = 1'b0, ff_en = 1'b0;
  logic [7:0] ss_lvl = '0, fb_lvl = '0, line_word = '0;
  logic [VS_W-1:0] vs_lim = '0;
  logic gate;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fwd_gate_pwm dut (.clk(clk), .rst_n(rst_n), .en(en), .kill(kill),
    .ss_lvl(ss_lvl), .fb_lvl(fb_lvl), .ff_en(ff_en), .line_word(line_word),
    .vs_lim(vs_lim), .gate(gate));

  function automatic int exp_on(int ss, int fb, int ff, int ln, int lim);
    int cmd, top, ncmd, nvs, n;
    cmd = (ss < fb) ? ss : fb;                    // R3
    top = ff ? ((ln * 169) >> 8) : TOPFIX;        // R6
    ncmd = 0;
    for (int q = 0; q < MAXON; q++) if (cmd * MAXON > q * top) ncmd++;  // R2, R1
    nvs = (ln == 0) ? 1000 : (lim / ln) + 1;      // R4
    n = ncmd;
    if (nvs < n) n = nvs;
    return n;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(int ss, int fb, int ff, int ln, int lim);
    @(negedge clk);
    ss_lvl = 8'(ss); fb_lvl = 8'(fb); ff_en = ff[0];
    line_word = 8'(ln); vs_lim = VS_W'(lim);
    repeat (2*PERIOD) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int rises);
    logic last;
    last = gate; hi = 0; rises = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(negedge clk);
      if (gate) hi++;
      if (gate && !last) rises++;
      last = gate;
    end
  endtask

  task automatic run_case(string tag, int ss, int fb, int ff, int ln, int lim);
    int hi, rs, e;
    apply(ss, fb, ff, ln, lim);
    e = exp_on(ss, fb, ff, ln, lim);
    measure(hi, rs);
    chk(tag, hi, e);
    chk({tag, " R8 rises"}, rs, (e > 0) ? 1 : 0);
  endtask

  initial begin
    int hi, rs, e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9 reset gate", int'(gate), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 en low gate", int'(gate), 0);
    en = 1'b1;

    run_case("R1 ceiling", 255, 255, 0, 1, 8000);
    run_case("R2 mid duty", 150, 255, 0, 1, 8000);
    run_case("R3 ss limits", 100, 200, 0, 1, 8000);
    run_case("R3 fb limits", 200, 100, 0, 1, 8000);
    run_case("R3 small ss", 50, 255, 0, 1, 8000);
    run_case("R8 zero cmd", 0, 255, 0, 1, 8000);
    run_case("R4 vs cut", 255, 255, 0, 10, 35);
    run_case("R4 vs exact", 255, 255, 0, 10, 40);
    run_case("R4 zero line", 255, 255, 0, 0, 0);
    run_case("R4 line over lim", 255, 255, 0, 200, 100);
    run_case("R6 ff wide", 100, 255, 1, 100, 8000);
    run_case("R6 ff narrow", 20, 255, 1, 100, 8000);
    // tie between duty compare and volt-second cut
    run_case("R2 tie", 100, 255, 0, 10, 55);

    // R5: volt-second cut repeats each period
    apply(255, 255, 0, 10, 35);
    measure(hi, rs); chk("R5 period a", hi, 4);
    measure(hi, rs); chk("R5 period b", hi, 4);

    // R7: kill at pulse start, gate off rest of period, resume next
    apply(255, 255, 0, 1, 8000);
    while (gate) @(negedge clk);
    while (!gate) @(negedge clk);
    kill = 1'b1;
    @(negedge clk);
    kill = 1'b0;
    chk("R7 kill off", int'(gate), 0);
    hi = 0;
    for (int i = 0; i < PERIOD-2; i++) begin
      @(negedge clk);
      if (gate) hi++;
    end
    chk("R7 stays off", hi, 0);
    @(negedge clk);
    chk("R7 resumes", int'(gate), 1);

    // R9: disable mid-run
    @(negedge clk); en = 1'b0;
    @(negedge clk); chk("R9 en drop", int'(gate), 0);
    en = 1'b1;

    for (int k = 0; k < 40; k++) begin
      int ss, fb, ff, ln, lim;
      ss = int'($urandom_range(0, 255)); fb = int'($urandom_range(0, 255));
      ff = int'($urandom_range(0, 1));  ln = int'($urandom_range(0, 255));
      lim = int'($urandom_range(0, 3000));
      run_case("R2 random", ss, fb, ff, ln, lim);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule